// File: doc/BRIEF.md
# APB Watchdog Countdown Timer

This block is a watchdog timer that sits on an APB bus. It holds a down-counter that moves one step on each single-cycle tick pulse. The pulse comes from a clock divider outside the block, so software can change the counting rate in the middle of a count. When the counter steps from one to zero, a sticky raw interrupt flag is set. On the next tick the counter reloads from a software-written reload value.

Software starts the timer by setting the enable bit and writing a reload value. The reload write takes effect on the counter at once. Software then services the watchdog by writing any data to the clear register. That write drops the flag and restarts the count in the same bus access. The interrupt output is the raw flag gated by the enable bit. A key register guards every other register against stray writes.

Top module: `wdt_apb_timer`

## Requirements
- R1: After reset, the reload register (offset 0x000) and the counter (offset 0x004) read 0xFFFFFFFF. The control register (0x008), the raw flag (0x010), the masked flag (0x014) and the lock status (0xC00) all read 0.
- R2: A write to offset 0x000 sets the reload register and the counter to the written value on the same clock edge. Bit 0 of the control register (0x008) is the enable bit, and it reads back.
- R3: While enabled, each tick pulse taken with the counter above zero decrements the counter by exactly one.
- R4: A tick that takes the counter from 1 to 0 sets the raw flag, which reads as bit 0 at 0x010. The counter then reads 0.
- R5: A tick taken while the counter is 0 reloads the counter from the reload register. The raw flag stays set.
- R6: A write of any data to offset 0x00C clears the raw flag and reloads the counter from the reload register on the same edge, with no tick needed.
- R7: The masked flag (bit 0 at 0x014) and the `irq_o` output both equal the raw flag ANDed with the enable bit.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the registers, and writing any other value locks them. Offset 0xC00 reads 1 while locked. While locked, writes to the reload, control and clear registers have no effect.
- R9: Every tick pulse counts exactly once, whatever the number of idle cycles between pulses. A change of rate during a count loses no count.
- R10: Every transfer completes with zero wait states, with `pready` high and `pslverr` low. Reads of unmapped offsets and of offset 0x00C return 0.
- R11: While the enable bit is 0, tick pulses leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer done, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| tick_en | input | 1 | Single-cycle count pulse from the external divider |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit counter and the standard unlock key. With these defaults the all-ones reset value and the full 0xC00 lock decode can be checked directly. A reload of 1000 then reaches zero, rests and reloads within a few thousand cycles. The bench sends tick pulses at several spacings to stand in for a divider that changes rate mid-count. It also runs the disabled and locked phases to show that ticks and writes are ignored at the registers and at `irq_o`.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_RELOAD = 12'h000;
  localparam logic [AW-1:0] OFS_COUNT  = 12'h004;
  localparam logic [AW-1:0] OFS_CTRL   = 12'h008;
  localparam logic [AW-1:0] OFS_CLEAR  = 12'h00C;
  localparam logic [AW-1:0] OFS_RAW    = 12'h010;
  localparam logic [AW-1:0] OFS_MASKED = 12'h014;
  localparam logic [AW-1:0] OFS_KEY    = 12'hC00;

  typedef enum logic [2:0] {
    SEL_RELOAD, SEL_COUNT, SEL_CTRL, SEL_CLEAR,
    SEL_RAW, SEL_MASKED, SEL_KEY, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
    case (a)
      OFS_RELOAD: decode_addr = SEL_RELOAD;
      OFS_COUNT:  decode_addr = SEL_COUNT;
      OFS_CTRL:   decode_addr = SEL_CTRL;
      OFS_CLEAR:  decode_addr = SEL_CLEAR;
      OFS_RAW:    decode_addr = SEL_RAW;
      OFS_MASKED: decode_addr = SEL_MASKED;
      OFS_KEY:    decode_addr = SEL_KEY;
      default:    decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  input  logic [CNT_W-1:0] count_i,
  input  logic             raw_i,
  output logic [CNT_W-1:0] reload_o,
  output logic             enable_o,
  output logic             masked_o,
  output logic             wr_reload_o,
  output logic             wr_clear_o,
  output logic [DW-1:0]    prdata_o
);
  reg_sel_e         sel;
  logic             acc_wr;
  logic             wr_ok;
  logic             wr_ctrl;
  logic             wr_key;
  logic             locked_q;
  logic             enable_q;
  logic [CNT_W-1:0] reload_q;

  assign sel         = decode_addr(paddr);
  assign acc_wr      = psel && penable && pwrite;
  assign wr_ok       = acc_wr && !locked_q;
  assign wr_reload_o = wr_ok && (sel == SEL_RELOAD);
  assign wr_ctrl     = wr_ok && (sel == SEL_CTRL);
  assign wr_clear_o  = wr_ok && (sel == SEL_CLEAR);
  assign wr_key      = acc_wr && (sel == SEL_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      enable_q <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (wr_reload_o) reload_q <= pwdata[CNT_W-1:0];
      if (wr_ctrl)     enable_q <= pwdata[0];
      if (wr_key)      locked_q <= (pwdata != UNLOCK_KEY);
    end
  end

  assign reload_o = reload_q;
  assign enable_o = enable_q;
  assign masked_o = raw_i & enable_q;

  always_comb begin
    prdata_o = '0;
    case (sel)
      SEL_RELOAD: prdata_o = DW'(reload_q);
      SEL_COUNT:  prdata_o = DW'(count_i);
      SEL_CTRL:   prdata_o = DW'(enable_q);
      SEL_RAW:    prdata_o = DW'(raw_i);
      SEL_MASKED: prdata_o = DW'(masked_o);
      SEL_KEY:    prdata_o = DW'(locked_q);
      default:    prdata_o = '0;
    endcase
  end

  // R8: a locked register file holds its values through any non-key write
  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && acc_wr && sel != SEL_KEY) |=> ($stable(reload_q) && $stable(enable_q)));

  // R8: the key register decides the lock state
  assert_key_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && pwdata == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             wr_reload_i,
  input  logic             wr_clear_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             raw_o,
  output logic             hit_zero_o
);
  logic [CNT_W-1:0] count_q;
  logic             raw_q;
  logic             cnt_tick;
  logic             bus_override;
  logic             rest_reload;

  // one tick step: rest at zero for a tick, then reload
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] rld);
    step = (cur == '0) ? rld : cur - 1'b1;
  endfunction

  assign cnt_tick     = tick_i && enable_i;
  assign bus_override = wr_reload_i || wr_clear_i;
  assign hit_zero_o   = cnt_tick && !bus_override && (count_q == CNT_W'(1));
  assign rest_reload  = cnt_tick && !bus_override && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
      raw_q   <= 1'b0;
    end else begin
      if (wr_reload_i)     count_q <= load_data_i;
      else if (wr_clear_i) count_q <= reload_val_i;
      else if (cnt_tick)   count_q <= step(count_q, reload_val_i);

      if (wr_clear_i)      raw_q <= 1'b0;
      else if (hit_zero_o) raw_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign raw_o   = raw_q;

  // R3: an enabled tick above zero removes exactly one count
  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !bus_override && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

  // R4: reaching zero raises the flag
  assert_flag_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_zero_o |=> (raw_q && count_q == '0));

  // R5: the tick after zero reloads and the flag is kept
  assert_rest_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_reload && raw_q) |=> (count_q == $past(reload_val_i) && raw_q));

  // R6: clear write drops the flag and restarts the count
  assert_clear_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear_i |=> (!raw_q && count_q == $past(reload_val_i)));

  // R11: disabled ticks leave the count alone
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !bus_override) |=> $stable(count_q));
endmodule

// File: rtl/wdt_apb_timer.sv
`timescale 1ns/1ps
module wdt_apb_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  input  logic        tick_en,
  output logic        irq_o
);
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] reload_w;
  logic             raw_w;
  logic             enable_w;
  logic             masked_w;
  logic             wr_reload_w;
  logic             wr_clear_w;
  logic             hit_zero_w;

  wdt_regs #(.CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk(pclk), .rst_n(presetn),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata),
    .count_i(count_w), .raw_i(raw_w),
    .reload_o(reload_w), .enable_o(enable_w), .masked_o(masked_w),
    .wr_reload_o(wr_reload_w), .wr_clear_o(wr_clear_w),
    .prdata_o(prdata)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(pclk), .rst_n(presetn),
    .tick_i(tick_en), .enable_i(enable_w),
    .wr_reload_i(wr_reload_w), .wr_clear_i(wr_clear_w),
    .load_data_i(pwdata[CNT_W-1:0]), .reload_val_i(reload_w),
    .count_o(count_w), .raw_o(raw_w), .hit_zero_o(hit_zero_w)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq_o   = masked_w;

  // R4: the flag never rises without a counter reaching zero
  assert_flag_rise_cause_R4: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(raw_w) |-> $past(hit_zero_w));
endmodule

// File: tb/tb_wdt_apb_timer.sv
`timescale 1ns/1ps
module tb_wdt_apb_timer;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, tick_en = 1'b0, irq_o;

  always #2 pclk = ~pclk;

  wdt_apb_timer dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .tick_en(tick_en), .irq_o(irq_o)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // independent reference model
  logic [31:0] m_reload, m_count;
  logic        m_en, m_raw, m_locked;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h000: return m_reload;
      12'h004: return m_count;
      12'h008: return {31'b0, m_en};
      12'h010: return {31'b0, m_raw};
      12'h014: return {31'b0, m_raw & m_en};
      12'hC00: return {31'b0, m_locked};
      default: return 32'h0;
    endcase
  endfunction

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge pclk); #1 penable = 1'b1;
    @(posedge pclk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    if (a == 12'hC00) m_locked = (d != KEY);
    else if (!m_locked) begin
      case (a)
        12'h000: begin m_reload = d; m_count = d; end
        12'h008: m_en = d[0];
        12'h00C: begin m_raw = 1'b0; m_count = m_reload; end
        default: ;
      endcase
    end
  endtask

  task automatic apb_read(input logic [11:0] a, input string tag);
    item_t it;
    it.exp = model_read(a);
    it.tag = tag;
    sb.push_back(it);
    @(posedge pclk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge pclk); #1 penable = 1'b1;
    @(posedge pclk); #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge pclk); #1 tick_en = 1'b1;
      if (m_en) begin
        if (m_count == 0) m_count = m_reload;
        else begin
          m_count = m_count - 1;
          if (m_count == 0) m_raw = 1'b1;
        end
      end
      @(posedge pclk); #1 tick_en = 1'b0;
      repeat (gap) @(posedge pclk);
    end
  endtask

  task automatic chk_irq(input string tag);
    vectors++;
    if (irq_o !== (m_raw & m_en)) begin
      miscompares++;
      $display("FAIL %s irq_o actual %0b expected %0b", tag, irq_o, m_raw & m_en);
    end
  endtask

  // monitor: pops expected items as read accesses complete
  always @(negedge pclk) begin
    item_t it;
    if (psel && penable && !pwrite) begin
      if (sb.size() == 0) begin
        miscompares++;
        $display("FAIL R10 unexpected read, actual %h expected none", prdata);
      end else begin
        it = sb.pop_front();
        vectors++;
        if (prdata !== it.exp || pready !== 1'b1 || pslverr !== 1'b0) begin
          miscompares++;
          $display("FAIL %s addr %h actual %h/%b/%b expected %h/1/0",
                   it.tag, paddr, prdata, pready, pslverr, it.exp);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired, actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_reload = '1; m_count = '1; m_en = 1'b0; m_raw = 1'b0; m_locked = 1'b0;
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;

    // R1 reset state
    apb_read(12'h000, "R1 reload reset");
    apb_read(12'h004, "R1 count reset");
    apb_read(12'h008, "R1 ctrl reset");
    apb_read(12'h010, "R1 raw reset");
    apb_read(12'h014, "R1 masked reset");
    apb_read(12'hC00, "R1 lock reset");
    chk_irq("R1 irq reset");

    // R11: disabled, ticks ignored
    ticks(5, 0);
    apb_read(12'h004, "R11 count frozen");

    // R2 load and enable
    apb_write(12'h008, 32'h1);
    apb_read(12'h008, "R2 ctrl readback");
    apb_write(12'h000, 32'd1000);
    apb_read(12'h004, "R2 count set at once");
    apb_read(12'h000, "R2 reload readback");

    // R3 counting
    ticks(500, 0);
    apb_read(12'h004, "R3 count after 500");
    apb_read(12'h010, "R3 raw still clear");

    // R4 reaching zero
    ticks(500, 0);
    apb_read(12'h004, "R4 count at zero");
    apb_read(12'h010, "R4 raw set");
    apb_read(12'h014, "R7 masked set");
    chk_irq("R7 irq set");

    // R5 reload after resting tick
    ticks(1, 0);
    apb_read(12'h004, "R5 reloaded");
    apb_read(12'h010, "R5 raw kept");

    // R6 clear with arbitrary data
    ticks(500, 0);
    apb_read(12'h004, "R6 count before clear");
    apb_write(12'h00C, 32'hDEADBEEF);
    apb_read(12'h004, "R6 count reloaded");
    apb_read(12'h010, "R6 raw cleared");
    apb_read(12'h00C, "R10 clear reads zero");
    chk_irq("R6 irq cleared");

    // R9 rate changes mid-count
    ticks(300, 0);
    ticks(200, 3);
    apb_read(12'h004, "R9 count after mixed rate");
    ticks(499, 1);
    apb_read(12'h004, "R9 count at one");
    ticks(1, 5);
    apb_read(12'h004, "R9 count at zero");
    apb_read(12'h010, "R9 raw set");

    // R7 / R11 disable masks interrupt and freezes count
    apb_write(12'h008, 32'h0);
    apb_read(12'h014, "R7 masked off when disabled");
    apb_read(12'h010, "R7 raw still set");
    chk_irq("R7 irq off when disabled");
    ticks(10, 0);
    apb_read(12'h004, "R11 count held at zero");
    apb_write(12'h008, 32'h1);
    chk_irq("R7 irq back on");
    ticks(1, 0);
    apb_read(12'h004, "R5 reload after enable");

    // R8 lock
    apb_write(12'hC00, 32'h0);
    apb_read(12'hC00, "R8 locked reads one");
    apb_write(12'h000, 32'd5);
    apb_read(12'h000, "R8 reload write ignored");
    apb_read(12'h004, "R8 count untouched");
    apb_write(12'h00C, 32'h0);
    apb_read(12'h010, "R8 clear ignored");
    apb_write(12'h008, 32'h0);
    apb_read(12'h008, "R8 ctrl write ignored");
    chk_irq("R8 irq kept while locked");
    apb_write(12'hC00, KEY);
    apb_read(12'hC00, "R8 unlocked reads zero");
    apb_write(12'h00C, 32'h1);
    apb_read(12'h010, "R8 clear works after unlock");

    // R10 unmapped
    apb_read(12'h020, "R10 unmapped reads zero");
    apb_read(12'h800, "R10 unmapped high reads zero");

    repeat (4) @(posedge pclk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule